// File: doc/BRIEF.md
# Bit-Serial Signed Booth Multiplier

This block multiplies a signed multiplicand, captured in parallel into a holding register, by a signed multiplier that arrives one bit per clock, least significant bit first. The product leaves as a serial stream, also least significant bit first, one bit per accepted input bit. The arithmetic is a row of identical one-bit cells, one per multiplicand bit plus a sign-guard cell on top. Each cell holds a single carry flip-flop and a one-bit adder, and hands its partial sum only to the cell below it. The incoming serial bit is the only signal that reaches every cell.

The current serial bit and the one before it are Booth-recoded into one of three actions for the whole row: add the multiplicand, subtract it, or do nothing. A subtraction adds the inverted multiplicand bits, and its "+1" goes into a small serial correction adder at the output. For a multiplicand of M bits and a multiplier of N bits, the driver sends the multiplier sign-extended to M+N bits. The M+N output bits are then the exact two's-complement product. A bit-valid qualifier lets the stream stall at any point. A frame-start flag, given together with the first bit, begins a new product.

Top module: `sbp_booth_mult`

## Requirements
- R1: While reset is asserted and after it is released, before any bit is accepted, `prod_valid` and `prod_bit` are 0.
- R2: A cycle with `load_en` high captures `mcand_in` as the multiplicand. A cycle with `load_en` low leaves the held multiplicand unchanged, whatever `mcand_in` carries.
- R3: For a multiplicand A of MCAND_W bits and a multiplier B sent as its own bits followed by sign-extension bits, MCAND_W+N bits in all (LSB first), the accepted output bits in order form the low MCAND_W+N bits of the signed product A*B, LSB first.
- R4: Each bit accepted on a clock edge (`bit_valid` high) yields its product bit on `prod_bit` with `prod_valid` high right after that same edge, which is a one-clock latency.
- R5: Booth recoding uses the pair (current bit, previous bit). Pair 1,0 subtracts the multiplicand, pair 0,1 adds it, and pairs 0,0 and 1,1 leave the partial sums alone. The previous bit is taken as 0 on the frame-start bit. Runs of ones, alternating patterns and all-ones multipliers all give the R3 product.
- R6: An accepted bit with `frame_start` high clears all partial sums, carries and the previous-bit state before that bit is used. A frame started part-way through another frame gives only the new frame's product.
- R7: A cycle with `bit_valid` low changes no internal state and drives `prod_valid` low while `prod_bit` holds its value. Gaps anywhere in a frame leave the product unchanged.
- R8: The extreme operands are exact. Most-negative times most-negative gives +2^(MCAND_W+N-2), and most-positive and most-negative combinations are also exact.
- R9: `frame_start` is ignored in a cycle where `bit_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Capture `mcand_in` as the multiplicand |
| mcand_in | input | MCAND_W | Signed parallel multiplicand |
| bit_valid | input | 1 | Serial multiplier bit present this cycle |
| frame_start | input | 1 | Marks the first (LSB) bit of a new product |
| bit_in | input | 1 | Serial multiplier bit, LSB first, sign-extended |
| prod_bit | output | 1 | Serial product bit, LSB first |
| prod_valid | output | 1 | `prod_bit` carries a new product bit |

## Verification
The embedded properties assume a few things about the driver. The multiplicand is reloaded only between frames. `frame_start` comes with the first accepted bit of each frame. The serial stream is sign-extended by the driver, not by the block. The stimulus loads the multiplicand with the stream idle before each frame and sends exactly MCAND_W+N extended bits per frame. It raises `frame_start` with a low `bit_valid` only in the one scenario that checks it is ignored. Stalls, aborted frames and changes on `mcand_in` without a load are all placed between accepted bits, so the recoder never sees a pair that spans two frames except through the frame-start clear.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

  typedef struct packed {
    logic sum;
    logic carry;
  } fa_t;

  function automatic fa_t full_add(input logic a, input logic b, input logic c);
    fa_t r;
    r.sum   = a ^ b ^ c;
    r.carry = (a & b) | (a & c) | (b & c);
    return r;
  endfunction

endpackage

// File: rtl/sbp_booth_recoder.sv
module sbp_booth_recoder
  import sbp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_en,
  input  logic      frame_clr,
  input  logic      bit_in,
  output booth_op_e op
);

  logic prev_q;
  logic prev_d;
  logic prev_eff;

  // previous bit reads as zero on the first bit of a frame
  always_comb begin
    prev_eff = frame_clr ? 1'b0 : prev_q;
  end

  always_comb begin
    unique case ({bit_in, prev_eff})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_NONE;
    endcase
  end

  always_comb begin
    prev_d = step_en ? bit_in : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  // R5: two equal consecutive accepted bits inside a frame never act
  p_equal_pair_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && $past(step_en) && !frame_clr && (bit_in == $past(bit_in)))
      |-> (op == OP_NONE));

  // R5/R6: a frame never starts with an add
  p_start_no_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr |-> (op != OP_ADD));

  // R7: a stalled cycle leaves the previous-bit state alone
  p_prev_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> (prev_q == $past(prev_q)));

endmodule

// File: rtl/sbp_cell.sv
module sbp_cell
  import sbp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_en,
  input  logic      frame_clr,
  input  logic      mc_bit,
  input  booth_op_e op,
  input  logic      sum_in,
  output logic      sum_out
);

  logic carry_q;
  logic carry_d;
  logic carry_eff;
  logic addend;
  fa_t  fa;

  always_comb begin
    unique case (op)
      OP_ADD:  addend = mc_bit;
      OP_SUB:  addend = ~mc_bit;
      default: addend = 1'b0;
    endcase
  end

  always_comb begin
    carry_eff = frame_clr ? 1'b0 : carry_q;
    fa        = full_add(sum_in, addend, carry_eff);
    sum_out   = fa.sum;
    carry_d   = step_en ? fa.carry : carry_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end

  // R5: with no operation selected a clear carry cannot become set
  p_idle_no_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !frame_clr && (op == OP_NONE) && !carry_q) |=> !carry_q);

  // R7: a stalled cycle leaves the carry alone
  p_carry_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(carry_q));

endmodule

// File: rtl/sbp_out_stage.sv
module sbp_out_stage
  import sbp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic frame_clr,
  input  logic raw_bit,
  input  logic sub_now,
  output logic prod_bit,
  output logic prod_valid
);

  logic fix_q;
  logic fix_d;
  logic fix_eff;
  logic bit_q;
  logic bit_d;
  logic vld_q;
  logic vld_d;
  fa_t  fa;

  // serial correction adder: adds the +1 of every subtraction at its weight
  always_comb begin
    fix_eff = frame_clr ? 1'b0 : fix_q;
    fa      = full_add(raw_bit, sub_now, fix_eff);
    fix_d   = step_en ? fa.carry : fix_q;
    bit_d   = step_en ? fa.sum : bit_q;
    vld_d   = step_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_q <= 1'b0;
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      fix_q <= fix_d;
      bit_q <= bit_d;
      vld_q <= vld_d;
    end
  end

  assign prod_bit   = bit_q;
  assign prod_valid = vld_q;

  // R4: an accepted bit produces a valid output one clock later
  p_one_clock_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> prod_valid);

  // R7: no accepted bit, no valid output, and the output bit holds
  p_stall_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> (!prod_valid && $stable(prod_bit)));

endmodule

// File: rtl/sbp_booth_mult.sv
module sbp_booth_mult
  import sbp_pkg::*;
#(
  parameter int MCAND_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [MCAND_W-1:0] mcand_in,
  input  logic               bit_valid,
  input  logic               frame_start,
  input  logic               bit_in,
  output logic               prod_bit,
  output logic               prod_valid
);

  localparam int CELLS = MCAND_W + 1;  // data cells plus sign guard

  logic [MCAND_W-1:0] mcand_q;
  logic [MCAND_W-1:0] mcand_d;
  logic [MCAND_W-1:0] psum_q;
  logic [MCAND_W-1:0] psum_d;
  logic [MCAND_W-1:0] psum_eff;
  logic [CELLS-1:0]   cell_sum;
  logic               frame_clr;
  logic               sub_now;
  booth_op_e          op;

  // multiplicand holding register
  always_comb begin
    mcand_d = load_en ? mcand_in : mcand_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mcand_q <= '0;
    else        mcand_q <= mcand_d;
  end

  // frame start only counts on an accepted bit
  always_comb begin
    frame_clr = frame_start & bit_valid;
    psum_eff  = frame_clr ? '0 : psum_q;
    sub_now   = (op == OP_SUB);
  end

  sbp_booth_recoder u_recoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (bit_valid),
    .frame_clr (frame_clr),
    .bit_in    (bit_in),
    .op        (op)
  );

  // cell g reads the partial sum at its own weight; its sum drops one place.
  // The guard cell stands for every cell above the word: they all share
  // one state, so it reads and rewrites the top partial-sum bit.
  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    logic sum_in_w;
    logic mc_w;
    if (g < MCAND_W) begin : g_data
      assign sum_in_w = psum_eff[g];
      assign mc_w     = mcand_q[g];
    end else begin : g_guard
      assign sum_in_w = psum_eff[MCAND_W-1];
      assign mc_w     = mcand_q[MCAND_W-1];
    end
    sbp_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_en   (bit_valid),
      .frame_clr (frame_clr),
      .mc_bit    (mc_w),
      .op        (op),
      .sum_in    (sum_in_w),
      .sum_out   (cell_sum[g])
    );
  end

  always_comb begin
    psum_d = bit_valid ? cell_sum[CELLS-1:1] : psum_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psum_q <= '0;
    else        psum_q <= psum_d;
  end

  sbp_out_stage u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (bit_valid),
    .frame_clr  (frame_clr),
    .raw_bit    (cell_sum[0]),
    .sub_now    (sub_now),
    .prod_bit   (prod_bit),
    .prod_valid (prod_valid)
  );

  // R2: a load captures the presented multiplicand
  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (mcand_q == $past(mcand_in)));

  // R2: without a load the multiplicand holds
  p_mcand_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(mcand_q));

  // R7 and R9: a cycle without an accepted bit leaves the partial sums alone
  p_psum_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(psum_q));

  // R1: outputs come out of reset idle
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!prod_valid && !prod_bit));

endmodule

// File: tb/sbp_booth_mult_test.sv
module sbp_booth_mult_test;

  localparam int MW         = 8;
  localparam int SW         = 8;
  localparam int PW         = MW + SW;
  localparam int CLK_PERIOD = 10;

  logic          clk;
  logic          rst_n;
  logic          load_en;
  logic [MW-1:0] mcand_in;
  logic          bit_valid;
  logic          frame_start;
  logic          bit_in;
  logic          prod_bit;
  logic          prod_valid;

  int checks;
  int errors;
  bit done;

  sbp_booth_mult #(.MCAND_W(MW)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (load_en),
    .mcand_in    (mcand_in),
    .bit_valid   (bit_valid),
    .frame_start (frame_start),
    .bit_in      (bit_in),
    .prod_bit    (prod_bit),
    .prod_valid  (prod_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic st, input logic b,
                      output logic gv, output logic gb);
    bit_valid   = v;
    frame_start = st;
    bit_in      = b;
    @(posedge clk);
    @(negedge clk);
    gv = prod_valid;
    gb = prod_bit;
  endtask

  task automatic load(input logic [MW-1:0] a);
    bit_valid   = 1'b0;
    frame_start = 1'b0;
    load_en     = 1'b1;
    mcand_in    = a;
    @(posedge clk);
    @(negedge clk);
    load_en     = 1'b0;
  endtask

  // one full frame: optional load, optional gaps, then checks of product,
  // latency and stall behaviour
  task automatic run_frame(input logic [MW-1:0] a, input logic [SW-1:0] b,
                           input bit do_load, input int gap_every,
                           input bit start_in_gap, input string req);
    logic [PW-1:0]        bx;
    logic [PW-1:0]        got;
    logic signed [PW-1:0] ea;
    logic signed [PW-1:0] eb;
    logic [PW-1:0]        exp;
    logic                 gv;
    logic                 gb;
    bit                   lat_ok;
    bit                   stall_ok;
    bx = {{MW{b[SW-1]}}, b};
    if (do_load) load(a);
    else mcand_in = ~a;  // visible on the port, but no load
    lat_ok   = 1'b1;
    stall_ok = 1'b1;
    got      = '0;
    for (int k = 0; k < PW; k++) begin
      if (gap_every > 0 && k > 0 && (k % gap_every) == 0) begin
        step(1'b0, start_in_gap, ~bx[k], gv, gb);
        if (gv || gb !== got[k-1]) stall_ok = 1'b0;
      end
      step(1'b1, (k == 0), bx[k], gv, gb);
      if (gv !== 1'b1) lat_ok = 1'b0;
      got[k] = gb;
    end
    bit_valid   = 1'b0;
    frame_start = 1'b0;
    ea  = $signed({{SW{a[MW-1]}}, a});
    eb  = $signed(bx);
    exp = ea * eb;
    check(got === exp, req, 64'(got), 64'(exp));
    check(lat_ok, "R4 one-clock latency", 64'(lat_ok), 64'd1);
    if (gap_every > 0)
      check(stall_ok, "R7 stall holds output", 64'(stall_ok), 64'd1);
  endtask

  task automatic t_reset;
    rst_n       = 1'b0;
    load_en     = 1'b0;
    mcand_in    = '0;
    bit_valid   = 1'b0;
    frame_start = 1'b0;
    bit_in      = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(prod_valid === 1'b0 && prod_bit === 1'b0, "R1 in reset",
          {62'd0, prod_valid, prod_bit}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(prod_valid === 1'b0 && prod_bit === 1'b0, "R1 after release",
          {62'd0, prod_valid, prod_bit}, 64'd0);
  endtask

  task automatic t_basic;
    run_frame(8'd3,   8'd5,   1'b1, 0, 1'b0, "R3 3*5");
    run_frame(8'hF9,  8'd9,   1'b1, 0, 1'b0, "R3 -7*9");
    run_frame(8'd0,   8'h9C,  1'b1, 0, 1'b0, "R3 0*-100");
    run_frame(8'd77,  8'd0,   1'b1, 0, 1'b0, "R3 77*0");
    run_frame(8'h85,  8'hE3,  1'b1, 0, 1'b0, "R3 neg*neg");
  endtask

  task automatic t_booth_patterns;
    run_frame(8'd37,  8'h7F,  1'b1, 0, 1'b0, "R5 long run of ones");
    run_frame(8'hC5,  8'hAA,  1'b1, 0, 1'b0, "R5 alternating 10");
    run_frame(8'd101, 8'h55,  1'b1, 0, 1'b0, "R5 alternating 01");
    run_frame(8'h93,  8'hFF,  1'b1, 0, 1'b0, "R5 all ones");
    run_frame(8'd59,  8'h01,  1'b1, 0, 1'b0, "R5 first bit subtract");
    run_frame(8'hA7,  8'h70,  1'b1, 0, 1'b0, "R5 inner run");
  endtask

  task automatic t_extremes;
    run_frame(8'h80, 8'h80, 1'b1, 0, 1'b0, "R8 min*min");
    run_frame(8'h80, 8'h7F, 1'b1, 0, 1'b0, "R8 min*max");
    run_frame(8'h7F, 8'h80, 1'b1, 0, 1'b0, "R8 max*min");
    run_frame(8'h7F, 8'h7F, 1'b1, 0, 1'b0, "R8 max*max");
  endtask

  task automatic t_load;
    run_frame(8'd45, 8'hD7, 1'b1, 0, 1'b0, "R2 loaded multiplicand");
    run_frame(8'd45, 8'h3B, 1'b0, 0, 1'b0, "R2 no load keeps multiplicand");
    run_frame(8'hB2, 8'h3B, 1'b1, 0, 1'b0, "R2 reload");
  endtask

  task automatic t_gaps;
    run_frame(8'hE1, 8'h6D, 1'b1, 1, 1'b0, "R7 gap every bit");
    run_frame(8'h4C, 8'h92, 1'b1, 5, 1'b0, "R7 sparse gaps");
  endtask

  task automatic t_start_ignored;
    run_frame(8'h39, 8'hCB, 1'b1, 3, 1'b1, "R9 start with no valid");
  endtask

  task automatic t_abort;
    logic gv;
    logic gb;
    load(8'hD4);
    for (int k = 0; k < 6; k++) step(1'b1, (k == 0), 1'b1, gv, gb);
    // previous bit is 1 here; new frame begins with a 0 bit
    run_frame(8'h2B, 8'h56, 1'b1, 0, 1'b0, "R6 restart after partial frame");
    load(8'h6E);
    for (int k = 0; k < 4; k++) step(1'b1, (k == 0), k[0], gv, gb);
    run_frame(8'h6E, 8'hB4, 1'b0, 0, 1'b0, "R6 restart without reload");
  endtask

  task automatic t_random;
    for (int n = 0; n < 24; n++) begin
      logic [MW-1:0] ra;
      logic [SW-1:0] rb;
      ra = MW'($urandom);
      rb = SW'($urandom);
      run_frame(ra, rb, 1'b1, (n % 4 == 3) ? 4 : 0, 1'b0, "R3 random operands");
    end
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    t_reset();
    t_basic();
    t_booth_patterns();
    t_extremes();
    t_load();
    t_gaps();
    t_start_ignored();
    t_abort();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule